// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Parity Status

This block receives asynchronous serial characters on a single line and delivers them through a small first-in first-out buffer. A free-running oversampling tick, 16 pulses per bit time by default, drives it. The block aligns its sampling phase to the falling edge of each start bit and takes a majority vote of three samples around the middle of every bit. When parity checking is enabled, it compares the received parity bit with the parity of the data bits. The parity verdict and the stop-bit verdict are written into the buffer entry of the character they belong to.

The surrounding logic reads characters through a pop-on-read port. The port shows the data, the parity-error bit and the framing-error bit of the oldest unread character. A receive-ready output is high whenever something is waiting. An overrun output reports that a character was lost because the buffer was full. Pulling the enable input low aborts any character in flight and empties the buffer at once.

Top module: `uart_rx_pbuf`

## Requirements
- R1: Parity checking is on only while `par_mode[1]` is 1 when a start bit is accepted. When checking is on, a parity bit follows the data bits. When it is off, no parity bit is expected and the stored parity-error bit is 0.
- R2: `par_mode[0]` picks the sense of the check. With 0 (even), the data bits plus the parity bit must hold an even number of ones. With 1 (odd), they must hold an odd number. A mismatch sets the parity-error bit of that character.
- R3: A character is one low start bit, then `DATA_W` data bits with the least significant bit first, then the optional parity bit, then one stop bit. `rd_data` returns the data bits with bit 0 being the first bit received.
- R4: The parity-error and framing-error bits are stored with each character when it arrives. Changing `par_mode` afterwards does not alter the bits of characters already buffered.
- R5: A stop bit that votes to 0 sets the framing-error bit in that character's entry. The character is still stored.
- R6: The buffer holds `DEPTH` (default 2) characters in arrival order. `rx_ready` is high exactly while it is not empty. A cycle with `rd_en` high pops the head. While the buffer is empty, `rd_data`, `rd_par_err` and `rd_frm_err` read 0.
- R7: A character that completes while the buffer is full, with no pop in that cycle, is dropped and sets `overrun`. `overrun` clears on the next pop or when the receiver is disabled.
- R8: While `rx_en` is 0, a character in progress is abandoned, the buffer is emptied, `overrun` is cleared and the line is ignored.
- R9: Each bit value is the majority of ticks 8, 9 and 10 of its 16-tick bit period, counted from the tick that saw the start edge as tick 1. A single deviating sample does not change the bit.
- R10: A falling edge starts a character only if the start bit still votes low at mid-bit. Otherwise the receiver returns to idle and stores nothing.
- R11: After reset the buffer is empty, `rx_ready` and `overrun` are 0, and the read outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en | input | 1 | Receiver enable; low aborts reception and flushes the buffer |
| baud_tick | input | 1 | One-cycle pulse, OVS pulses per bit time |
| par_mode | input | 2 | [1] parity check on, [0] 1 = odd, 0 = even |
| rxd | input | 1 | Serial line, idle high |
| rd_en | input | 1 | Pop the head character |
| rd_data | output | DATA_W | Data bits of the head character |
| rd_par_err | output | 1 | Parity error of the head character |
| rd_frm_err | output | 1 | Framing error of the head character |
| rx_ready | output | 1 | Buffer holds at least one character |
| overrun | output | 1 | A character was dropped because the buffer was full |

## Verification
The bench injects a one-sample glitch at the middle of a data bit. A receiver that takes a single sample instead of voting would flip that bit. It sends a start pulse shorter than half a bit. A receiver without start confirmation would store a garbage character. It drops `rx_en` in the middle of a character and then holds the line idle. A design that does not abort would finish the frame from the idle ones and store it. It also fills the buffer past capacity and changes `par_mode` while characters wait. Those steps expose a wrong overrun policy and parity status evaluated at read time instead of arrival time.

// File: rtl/urx_pkg.sv
package urx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/urx_rst_sync.sv
module urx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/urx_frame.sv
module urx_frame
  import urx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              tick,
  input  logic [1:0]        par_mode,
  input  logic              rx,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ferr
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] SMP_A    = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] SMP_B    = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] SMP_C    = CNT_W'(OVS / 2 + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [1:0]        smp_q, smp_d;
  logic              prev_q, prev_d;
  logic              bit_q, bit_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic              pen_q, pen_d;
  logic              podd_q, podd_d;
  logic              pbit_q, pbit_d;
  logic              valid_q, valid_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              perr_q, perr_d;
  logic              ferr_q, ferr_d;
  logic              vote;

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    smp_d   = smp_q;
    prev_d  = prev_q;
    bit_d   = bit_q;
    shreg_d = shreg_q;
    pen_d   = pen_q;
    podd_d  = podd_q;
    pbit_d  = pbit_q;
    valid_d = 1'b0;
    data_d  = data_q;
    perr_d  = perr_q;
    ferr_d  = ferr_q;
    vote    = maj3(smp_q[1], smp_q[0], rx);

    if (tick) prev_d = rx;

    if (!rx_en) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
    end else if (tick) begin
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
      if (cnt_q == SMP_A || cnt_q == SMP_B) smp_d = {smp_q[0], rx};

      if (state_q == ST_IDLE) begin
        cnt_d = '0;
        if (prev_q && !rx) begin
          state_d = ST_START;
          cnt_d   = CNT_ONE;
          pen_d   = par_mode[1];
          podd_d  = par_mode[0];
        end
      end else begin
        if (cnt_q == SMP_C) begin
          bit_d = vote;
          if (state_q == ST_START && vote) state_d = ST_IDLE;
          if (state_q == ST_STOP) begin
            valid_d = 1'b1;
            data_d  = shreg_q;
            perr_d  = pen_q & ((^shreg_q) ^ pbit_q ^ podd_q);
            ferr_d  = !vote;
            state_d = ST_IDLE;
          end
        end
        if (cnt_q == CNT_LAST) begin
          case (state_q)
            ST_START: begin
              state_d = ST_DATA;
              idx_d   = '0;
            end
            ST_DATA: begin
              shreg_d = {bit_q, shreg_q[DATA_W-1:1]};
              if (idx_q == IDX_LAST) state_d = pen_q ? ST_PAR : ST_STOP;
              else                   idx_d   = idx_q + 1'b1;
            end
            ST_PAR: begin
              pbit_d  = bit_q;
              state_d = ST_STOP;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      smp_q   <= '1;
      prev_q  <= 1'b1;
      bit_q   <= 1'b1;
      shreg_q <= '0;
      pen_q   <= 1'b0;
      podd_q  <= 1'b0;
      pbit_q  <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      smp_q   <= smp_d;
      prev_q  <= prev_d;
      bit_q   <= bit_d;
      shreg_q <= shreg_d;
      pen_q   <= pen_d;
      podd_q  <= podd_d;
      pbit_q  <= pbit_d;
      valid_q <= valid_d;
      data_q  <= data_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign out_perr  = perr_q;
  assign out_ferr  = ferr_q;

  // R8: a low enable returns the framer to idle on the next edge
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> state_q == ST_IDLE);

  // R3: a completed character is reported for exactly one cycle
  p_single_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R10: a start bit that votes high at mid-bit never reaches the data phase
  p_false_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && tick && state_q == ST_START && cnt_q == SMP_C && vote) |=> state_q == ST_IDLE);
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head_data,
  output logic         not_empty,
  output logic         overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovr_q, ovr_d;
  logic             pop_ok, push_ok, drop;

  always_comb begin
    pop_ok  = pop && (cnt_q != '0);
    push_ok = push && ((cnt_q != FULL_CNT) || pop_ok);
    drop    = push && !push_ok;

    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    ovr_d = ovr_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
      ovr_d = 1'b0;
    end else begin
      if (push_ok) wr_d = (wr_q == PTR_LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_d = (rd_q == PTR_LAST) ? '0 : rd_q + 1'b1;
      cnt_d = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
      if (drop)        ovr_d = 1'b1;
      else if (pop_ok) ovr_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovr_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovr_q <= ovr_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic we;
    assign we = push_ok && !flush && (wr_q == PTR_W'(i));
    always_ff @(posedge clk) begin
      if (we) mem[i] <= push_data;
    end
  end

  assign not_empty = (cnt_q != '0);
  assign head_data = not_empty ? mem[rd_q] : '0;
  assign overrun   = ovr_q;

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0) && !ovr_q);

  p_drop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush && cnt_q == FULL_CNT) |=> ovr_q);

  p_last_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !flush && cnt_q == ONE_CNT) |=> !not_empty);
endmodule

// File: rtl/uart_rx_pbuf.sv
module uart_rx_pbuf #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              baud_tick,
  input  logic [1:0]        par_mode,
  input  logic              rxd,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_par_err,
  output logic              rd_frm_err,
  output logic              rx_ready,
  output logic              overrun
);
  localparam int ENTRY_W = DATA_W + 2;

  logic              rst_n_s;
  logic              rx_s;
  logic              f_valid;
  logic [DATA_W-1:0] f_data;
  logic              f_perr;
  logic              f_ferr;
  logic [ENTRY_W-1:0] head;

  urx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  urx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d(rxd), .q(rx_s)
  );

  urx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk(clk), .rst_n(rst_n_s), .rx_en(rx_en), .tick(baud_tick),
    .par_mode(par_mode), .rx(rx_s),
    .out_valid(f_valid), .out_data(f_data), .out_perr(f_perr), .out_ferr(f_ferr)
  );

  urx_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n_s), .flush(!rx_en),
    .push(f_valid), .push_data({f_data, f_perr, f_ferr}), .pop(rd_en),
    .head_data(head), .not_empty(rx_ready), .overrun(overrun)
  );

  assign rd_data    = head[ENTRY_W-1:2];
  assign rd_par_err = head[1];
  assign rd_frm_err = head[0];
endmodule

// File: tb/uart_rx_pbuf_test.sv
module uart_rx_pbuf_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] par_mode = 2'b00;
  logic       rxd = 1'b1;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_par_err, rd_frm_err, rx_ready, overrun;
  int         n_chk = 0;
  int         n_bad = 0;

  uart_rx_pbuf uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .baud_tick(baud_tick),
    .par_mode(par_mode), .rxd(rxd), .rd_en(rd_en), .rd_data(rd_data),
    .rd_par_err(rd_par_err), .rd_frm_err(rd_frm_err),
    .rx_ready(rx_ready), .overrun(overrun)
  );

  always #10 clk = ~clk;

  // {data[7:0], par_mode[1:0], bad_parity, stop, exp_perr, exp_ferr}
  localparam logic [13:0] VEC [8] = '{
    {8'h55, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'hA3, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'hA3, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'h0F, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h0F, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0},
    {8'hFF, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h81, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive value v for n ticks; glitch index g inverts one tick
  task automatic drive_ticks(input logic v, input int n, input int g);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxd = (i == g) ? ~v : v;
      baud_tick = 1'b1;
      @(negedge clk);
      baud_tick = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] pm, input logic bad,
                      input logic stop, input bit glitch);
    drive_ticks(1'b0, 16, -1);
    for (int b = 0; b < 8; b++) drive_ticks(d[b], 16, (glitch && b == 0) ? 8 : -1);
    if (pm[1]) drive_ticks((^d) ^ pm[0] ^ bad, 16, -1);
    drive_ticks(stop, 16, -1);
    drive_ticks(1'b1, 16, -1);
  endtask

  task automatic pop;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 rx_ready", rx_ready, 0);
    chk("R11 overrun", overrun, 0);
    chk("R11 rd_data", rd_data, 0);
    chk("R11 flags", {rd_par_err, rd_frm_err}, 0);
    rx_en = 1'b1;
    drive_ticks(1'b1, 4, -1);

    // vector table: R1 R2 R3 R5
    for (int k = 0; k < 8; k++) begin
      par_mode = VEC[k][5:4];
      send(VEC[k][13:6], VEC[k][5:4], VEC[k][3], VEC[k][2], 1'b0);
      @(negedge clk);
      chk($sformatf("R6 ready vec%0d", k), rx_ready, 1);
      chk($sformatf("R3 data vec%0d", k), rd_data, VEC[k][13:6]);
      chk($sformatf("R1/R2 perr vec%0d", k), rd_par_err, VEC[k][1]);
      chk($sformatf("R5 ferr vec%0d", k), rd_frm_err, VEC[k][0]);
      pop();
      chk($sformatf("R6 empty vec%0d", k), rx_ready, 0);
    end

    // R4: status fixed at arrival, R6 ordering
    par_mode = 2'b10;
    send(8'h3C, 2'b10, 1'b1, 1'b1, 1'b0);
    send(8'hC5, 2'b10, 1'b0, 1'b1, 1'b0);
    par_mode = 2'b00;
    @(negedge clk);
    chk("R4 head perr kept", rd_par_err, 1);
    chk("R6 head first", rd_data, 8'h3C);
    pop();
    chk("R6 second", rd_data, 8'hC5);
    chk("R4 second perr", rd_par_err, 0);
    pop();
    chk("R6 empty data zero", rd_data, 0);

    // R7 overrun
    send(8'h11, 2'b00, 1'b0, 1'b1, 1'b0);
    send(8'h22, 2'b00, 1'b0, 1'b1, 1'b0);
    chk("R7 no overrun when just full", overrun, 0);
    send(8'h33, 2'b00, 1'b0, 1'b1, 1'b0);
    chk("R7 overrun set", overrun, 1);
    chk("R7 head kept", rd_data, 8'h11);
    pop();
    chk("R7 overrun cleared by pop", overrun, 0);
    chk("R7 second kept", rd_data, 8'h22);
    pop();
    chk("R7 third dropped", rx_ready, 0);

    // R8 flush
    send(8'h44, 2'b00, 1'b0, 1'b1, 1'b0);
    send(8'h66, 2'b00, 1'b0, 1'b1, 1'b0);
    send(8'h77, 2'b00, 1'b0, 1'b1, 1'b0);
    @(negedge clk); rx_en = 1'b0;
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk);
    chk("R8 flushed", rx_ready, 0);
    chk("R8 overrun cleared", overrun, 0);

    // R8 abort mid-character
    drive_ticks(1'b0, 16, -1);
    drive_ticks(1'b0, 16, -1);
    drive_ticks(1'b1, 16, -1);
    @(negedge clk); rx_en = 1'b0;
    repeat (3) @(negedge clk); rx_en = 1'b1;
    drive_ticks(1'b1, 192, -1);
    chk("R8 aborted character not stored", rx_ready, 0);

    // R8 line ignored while disabled
    rx_en = 1'b0;
    send(8'h5A, 2'b00, 1'b0, 1'b1, 1'b0);
    rx_en = 1'b1;
    drive_ticks(1'b1, 4, -1);
    chk("R8 ignored while disabled", rx_ready, 0);

    // R9 glitch on a data bit
    send(8'h96, 2'b00, 1'b0, 1'b1, 1'b1);
    chk("R9 glitch filtered", rd_data, 8'h96);
    pop();

    // R10 false start
    drive_ticks(1'b0, 4, -1);
    drive_ticks(1'b1, 200, -1);
    chk("R10 false start dropped", rx_ready, 0);
    send(8'hE7, 2'b11, 1'b0, 1'b1, 1'b0);
    chk("R10 recovers", rd_data, 8'hE7);
    chk("R10 recovers perr", rd_par_err, 0);
    pop();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule